// File: doc/BRIEF.md
# Boot Image Checksum Sealer and Checker

This block guards a fixed 1024-byte boot image. The image is handled as 256 little-endian 32-bit words. The block has two modes, both fed by a word stream that is started with a one-cycle start pulse.

In seal mode the block adds up the first 255 words. It treats the final slot as zero, then returns the word that must go into that final slot. With that word in place, the whole image adds up to the ASCII signature "Prop", which is 32'h706F7250. In check mode it adds up all 256 words as they arrive. When the run ends it raises a done strobe together with a verdict that says whether the image may be executed.

All sums use wrap-around 32-bit arithmetic. The block does not store the image and does not fetch it from flash.

Top module: `boot_image_sealer`

## Requirements
- R1: After reset the block is idle: `wordReady`, `doneStrobe` and `imageGood` are 0, and `sealWord` is 0.
- R2: A start pulse begins a new run. The mode is taken from `sealMode` in the start cycle only, and later changes of `sealMode` have no effect on the run. `wordReady` is 0 in the start cycle and 1 from the next cycle until the run ends.
- R3: In check mode (`sealMode`=1'b0 at start), `imageGood` is 1 after the run exactly when the 32-bit sum of all 256 words equals 32'h706F7250, and 0 otherwise.
- R4: In seal mode (`sealMode`=1'b1 at start), the value of the 256th word is ignored. After the run `sealWord` equals 32'h706F7250 minus the sum of words 0 to 254, so an image carrying that word passes the check.
- R5: `doneStrobe` is high for exactly one cycle, the cycle after the 256th word is accepted, and `wordReady` is 0 from that cycle on.
- R6: A word is taken only in a cycle where `wordValid` and `wordReady` are both 1. Idle cycles inside the stream do not disturb the result, and words offered while the block is idle are ignored.
- R7: A start pulse that arrives before the run ends abandons that run without a done strobe, and word counting begins again from word 0.
- R8: The verdict and seal word keep their values until the next start pulse, which clears both to 0.
- R9: Additions discard carries, so the result is correct when the true sum exceeds 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | One-cycle pulse that starts (or restarts) a run |
| sealMode | input | 1 | 1 = seal, 0 = check; sampled with the start pulse |
| wordValid | input | 1 | Image word present on `wordData` |
| wordData | input | 32 | Image word, in order from word 0 |
| wordReady | output | 1 | Block accepts a word this cycle |
| doneStrobe | output | 1 | One-cycle end-of-run strobe |
| imageGood | output | 1 | Check-mode verdict: image sum matches the signature |
| sealWord | output | 32 | Seal-mode result for the final slot |

## Verification
Each pattern below is paired with a case that should produce the opposite result, so the bench can tell the two apart:
- A properly sealed image is checked next to the same image with one word altered. This shows that the verdict really depends on the sum.
- A seal run is given a junk final word, and its result is then fed back through a check run. This shows both that the final slot is ignored and that the seal closes the sum.
- An image of all-ones words pushes the running sum far past 32 bits, which exposes any carry handling.
- An image with bubbles between words, and a run restarted partway through, separate the handshake and the restart behaviour from the arithmetic.
- The mode input is flipped right after each start pulse, which shows whether the mode was latched at start.

// File: rtl/bootsum_pkg.sv
package bootsum_pkg;
  // Strobes from the control FSM to the summing datapath
  typedef struct packed {
    logic clearAcc;  // new run: clear accumulator and results
    logic addWord;   // a word is accepted this cycle
    logic zeroWord;  // accepted word is replaced by zero (seal slot)
    logic finish;    // accepted word is the last of the image
  } sumCtrl_t;
endpackage

// File: rtl/bootsum_ctrl.sv
module bootsum_ctrl
  import bootsum_pkg::*;
#(
  parameter int IMG_WORDS = 256
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     startPulse,
  input  logic     sealModeIn,
  input  logic     wordValid,
  output logic     wordReady,
  output logic     doneStrobe,
  output logic     sealModeQ,
  output sumCtrl_t ctrl
);
  localparam int CNT_W = $clog2(IMG_WORDS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(IMG_WORDS - 1);

  logic             running;
  logic [CNT_W-1:0] wordCount;
  logic             accept;
  logic             isLast;

  assign wordReady = running && !startPulse;
  assign accept    = wordValid && wordReady;
  assign isLast    = (wordCount == LAST_IDX);

  always_comb begin
    ctrl.clearAcc = startPulse;
    ctrl.addWord  = accept;
    ctrl.finish   = accept && isLast;
    ctrl.zeroWord = accept && isLast && sealModeQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running    <= 1'b0;
      wordCount  <= '0;
      sealModeQ  <= 1'b0;
      doneStrobe <= 1'b0;
    end else begin
      doneStrobe <= ctrl.finish;
      if (startPulse) begin
        running   <= 1'b1;
        wordCount <= '0;
        sealModeQ <= sealModeIn;
      end else if (accept) begin
        wordCount <= wordCount + 1'b1;
        if (isLast) running <= 1'b0;
      end
    end
  end

  // R5: the done strobe never lasts two cycles
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneStrobe |=> !doneStrobe);
  // R5: no word is taken after the last one
  a_r5_idle_after_last: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.finish |=> !wordReady);
  // R2: the start cycle takes no word
  a_r2_start_blocks_ready: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> !wordReady);
  // R7: a start always restarts counting from word 0
  a_r7_start_restarts: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> (wordCount == '0) && running);
endmodule

// File: rtl/bootsum_datapath.sv
module bootsum_datapath
  import bootsum_pkg::*;
#(
  parameter int               WORD_W    = 32,
  parameter logic [WORD_W-1:0] SIGNATURE = 32'h706F7250
) (
  input  logic              clk,
  input  logic              rstN,
  input  sumCtrl_t          ctrl,
  input  logic              sealMode,
  input  logic [WORD_W-1:0] wordData,
  output logic [WORD_W-1:0] sealWord,
  output logic              imageGood
);
  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] addend;
  logic [WORD_W-1:0] sumNext;

  assign addend  = ctrl.zeroWord ? '0 : wordData;
  assign sumNext = acc + addend;  // carry out dropped

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc       <= '0;
      sealWord  <= '0;
      imageGood <= 1'b0;
    end else if (ctrl.clearAcc) begin
      acc       <= '0;
      sealWord  <= '0;
      imageGood <= 1'b0;
    end else if (ctrl.addWord) begin
      acc <= sumNext;
      if (ctrl.finish) begin
        if (sealMode) sealWord  <= SIGNATURE - sumNext;
        else          imageGood <= (sumNext == SIGNATURE);
      end
    end
  end

  // R4: the seal word closes the accumulated sum onto the signature
  a_r4_seal_closes: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.finish && sealMode) |=> ((sealWord + acc) == SIGNATURE));
  // R3: the verdict agrees with the final accumulated sum
  a_r3_verdict_matches: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.finish && !sealMode) |=> (imageGood == (acc == SIGNATURE)));
  // R8: results only move on a start or at the end of a run
  a_r8_results_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.clearAcc && !ctrl.finish) |=> ($stable(sealWord) && $stable(imageGood)));
endmodule

// File: rtl/boot_image_sealer.sv
module boot_image_sealer
  import bootsum_pkg::*;
#(
  parameter int               WORD_W    = 32,
  parameter int               IMG_WORDS = 256,
  parameter logic [WORD_W-1:0] SIGNATURE = 32'h706F7250
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              sealMode,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordData,
  output logic              wordReady,
  output logic              doneStrobe,
  output logic              imageGood,
  output logic [WORD_W-1:0] sealWord
);
  sumCtrl_t ctrl;
  logic     sealModeQ;

  bootsum_ctrl #(.IMG_WORDS(IMG_WORDS)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .sealModeIn(sealMode),
    .wordValid (wordValid),
    .wordReady (wordReady),
    .doneStrobe(doneStrobe),
    .sealModeQ (sealModeQ),
    .ctrl      (ctrl)
  );

  bootsum_datapath #(.WORD_W(WORD_W), .SIGNATURE(SIGNATURE)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .sealMode (sealModeQ),
    .wordData (wordData),
    .sealWord (sealWord),
    .imageGood(imageGood)
  );
endmodule

// File: tb/sim_boot_image_sealer.sv
module sim_boot_image_sealer;
  localparam logic [31:0] SIG = 32'h706F7250;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic        sealIn = 1'b0;
  logic        validIn = 1'b0;
  logic [31:0] dataIn = '0;
  logic        wordReady, doneStrobe, imageGood;
  logic [31:0] sealWord;

  int checks = 0;
  int failures = 0;
  int doneSeen = 0;
  int cycles = 0;
  logic [31:0] img [256];

  // behavioural reference state
  bit          mRun, mSeal, mDone, mGood;
  int          mCnt;
  logic [31:0] mSum, mSealWord;

  always #5 clk = ~clk;

  boot_image_sealer u0 (
    .clk(clk), .rstN(rstN), .startPulse(startIn), .sealMode(sealIn),
    .wordValid(validIn), .wordData(dataIn), .wordReady(wordReady),
    .doneStrobe(doneStrobe), .imageGood(imageGood), .sealWord(sealWord)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: advances on every rising edge
  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mRun = 0; mSeal = 0; mDone = 0; mGood = 0; mCnt = 0; mSum = '0; mSealWord = '0;
    end else begin
      mDone = 0;
      if (startIn) begin
        mRun = 1; mCnt = 0; mSum = '0; mSeal = sealIn; mGood = 0; mSealWord = '0;
      end else if (validIn && mRun) begin
        mSum = mSum + ((mSeal && mCnt == 255) ? 32'h0 : dataIn);
        if (mCnt == 255) begin
          mDone = 1; mRun = 0;
          if (mSeal) mSealWord = SIG - mSum;
          else       mGood = (mSum == SIG);
        end
        mCnt++;
      end
    end
  end

  // compare outputs with the model every cycle, away from the edge
  always @(negedge clk) begin
    #3;
    if (rstN) begin
      if (doneStrobe) doneSeen++;
      chk(wordReady == (mRun && !startIn), "R6 ready", 32'(wordReady), 32'(mRun && !startIn));
      chk(doneStrobe == mDone, "R5 done", 32'(doneStrobe), 32'(mDone));
      chk(imageGood == mGood, "R3 verdict", 32'(imageGood), 32'(mGood));
      chk(sealWord == mSealWord, "R4 seal", sealWord, mSealWord);
    end
  end

  function automatic logic [31:0] sumFirst(input int n);
    logic [31:0] s = '0;
    for (int i = 0; i < n; i++) s = s + img[i];
    return s;
  endfunction

  task automatic fillImage(input logic [31:0] seed);
    for (int i = 0; i < 256; i++) img[i] = i * 32'h9E3779B9 + seed;
  endtask

  // one run; returns early when abortAt is reached
  task automatic sendImage(input bit seal, input int gapEvery, input int abortAt);
    @(negedge clk); startIn = 1; sealIn = seal; validIn = 0;
    @(negedge clk); startIn = 0; sealIn = ~seal;  // mode must be latched (R2)
    for (int i = 0; i < 256; i++) begin
      if (i == abortAt) begin validIn = 0; return; end
      if (gapEvery > 0 && i % gapEvery == 0) begin
        validIn = 0; @(negedge clk);
      end
      validIn = 1; dataIn = img[i];
      @(negedge clk);
    end
    validIn = 0;
    #1;
  endtask

  task automatic expectEnd(input string tag, input bit seal, input logic [31:0] expVal);
    chk(doneStrobe == 1'b1, "R5 done after last word", 32'(doneStrobe), 32'h1);
    chk(wordReady == 1'b0, "R5 ready drops", 32'(wordReady), 32'h0);
    if (seal) chk(sealWord == expVal, tag, sealWord, expVal);
    else      chk(32'(imageGood) == expVal, tag, 32'(imageGood), expVal);
    @(negedge clk); #1;
    chk(doneStrobe == 1'b0, "R5 done one cycle", 32'(doneStrobe), 32'h0);
  endtask

  initial begin
    logic [31:0] expSeal;
    int doneBefore;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // R1 reset state
    chk(wordReady == 0, "R1 ready", 32'(wordReady), 0);
    chk(doneStrobe == 0, "R1 done", 32'(doneStrobe), 0);
    chk(imageGood == 0, "R1 verdict", 32'(imageGood), 0);
    chk(sealWord == 0, "R1 seal", sealWord, 0);

    // R3 correctly sealed image passes
    fillImage(32'h1234_5678);
    img[255] = SIG - sumFirst(255);
    sendImage(0, 0, -1);
    expectEnd("R3 good image", 0, 32'h1);

    // R3 one altered word fails
    img[17] = img[17] ^ 32'h0000_0100;
    sendImage(0, 0, -1);
    expectEnd("R3 altered image", 0, 32'h0);

    // R4 seal with junk in the last slot, then check with the seal inserted
    fillImage(32'hCAFE_0001);
    img[255] = 32'hDEAD_BEEF;
    expSeal = SIG - sumFirst(255);
    sendImage(1, 0, -1);
    expectEnd("R4 seal value", 1, expSeal);
    img[255] = expSeal;
    sendImage(0, 0, -1);
    expectEnd("R4 sealed image passes", 0, 32'h1);

    // R9 wrap-around: sum of 255 all-ones words is 0xFFFFFF01 modulo 2^32
    for (int i = 0; i < 255; i++) img[i] = 32'hFFFF_FFFF;
    img[255] = 32'h0;
    sendImage(1, 0, -1);
    expectEnd("R9 seal with wrap", 1, SIG - 32'hFFFF_FF01);
    img[255] = SIG - 32'hFFFF_FF01;
    sendImage(0, 0, -1);
    expectEnd("R9 check with wrap", 0, 32'h1);

    // R6 bubbles between words
    fillImage(32'h0BAD_F00D);
    img[255] = SIG - sumFirst(255);
    sendImage(0, 3, -1);
    expectEnd("R6 gapped stream", 0, 32'h1);

    // R7 abort then full run: exactly one done
    doneBefore = doneSeen;
    sendImage(0, 0, 100);
    sendImage(0, 0, -1);
    expectEnd("R7 run after abort", 0, 32'h1);
    chk(doneSeen - doneBefore == 1, "R7 single done", 32'(doneSeen - doneBefore), 32'h1);

    // R8 and R6: idle words ignored, results hold
    for (int i = 0; i < 20; i++) begin
      validIn = i[0]; dataIn = 32'h5555_0000 + i;
      @(negedge clk);
    end
    validIn = 0; #1;
    chk(imageGood == 1'b1, "R8 verdict holds", 32'(imageGood), 32'h1);
    chk(doneSeen - doneBefore == 1, "R6 idle words ignored", 32'(doneSeen - doneBefore), 32'h1);
    @(negedge clk); startIn = 1; sealIn = 0;
    @(negedge clk); startIn = 0; #1;
    chk(imageGood == 1'b0, "R8 start clears verdict", 32'(imageGood), 32'h0);
    chk(wordReady == 1'b1, "R2 ready after start", 32'(wordReady), 32'h1);

    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule